// File: doc/BRIEF.md
# Gated Multi-Mode Timer/Counter

This block is a timer/counter for a small 8-bit controller subsystem. Two byte registers, a high byte and a low byte, hold the count. Software loads them through write strobes. A 2-bit mode field picks one of four counting structures over those two bytes:

- a 13-bit counter, made of a 5-bit prescaler and the 8-bit high byte;
- a 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a freeze mode that holds the count.

Each count step comes from one of two sources, selected by a source bit. The first is an internal tick strobe. The second is a falling edge on a synchronized external event pin.

Counting is qualified by two things. The first is a run bit. The second is an optional gate, which also requires a synchronized external active-low interrupt pin to be high.

On a rollover the block sets an overflow flag. It raises an interrupt request when that flag, a local enable and a global enable are all set. The flag clears when the interrupt is acknowledged.

A borrow input emulates a neighbouring timer that has taken over this timer's run bit and flag. While borrow is set, the run bit and the flag come from external inputs and the interrupt request is muted.

Top module: `gated_timer`

## Requirements
- R1: After reset, the high byte, the low byte and the flag read zero. The configuration (mode, source, gate, run) is also zero, and the interrupt request is low.
- R2: A step counts only when both of the following hold. First, the effective run bit is 1. Second, either the gate bit is 0 or the synchronized pin `gate_pin_ni` is high. Otherwise the count does not change. The configuration byte written with `wr_cfg_i` uses these bits of `wr_data_i`:
  - bits [1:0]: mode;
  - bit 2: source;
  - bit 3: gate;
  - bit 4: run.
- R3: Mode 0 is the 13-bit mode. Bits [4:0] of the low byte count modulo 32. When they wrap, the high byte increments. Bits [7:5] of the low byte never change in this mode.
- R4: Mode 1 counts {high, low} as one 16-bit value, with the low byte as the least significant part.
- R5: Mode 2 counts the low byte only. When the low byte is 0xFF, the next step loads it with the high byte. The high byte does not change in this mode.
- R6: Mode 3 holds both bytes, whatever the run bit, the borrowed run input or the step inputs are doing.
- R7: The flag sets on a rollover. In mode 0 that is high=0xFF with low[4:0]=0x1F. In mode 1 it is 0xFFFF. In mode 2 it is low=0xFF. The flag then stays set until `int_ack_i` clears it. A rollover and an acknowledge in the same cycle leave the flag set.
- R8: `irq_o` is high only when the flag, `ie_local_i` and `ie_global_i` are all 1 and borrow is off.
- R9: A high or low write in the same cycle as a step takes effect, and the whole step is dropped, including its rollover.
- R10: `wr_flag_i` loads the flag from `wr_data_i[0]`. This takes priority over a rollover and over an acknowledge in the same cycle.
- R11: With source 1, each falling edge of the synchronized `evt_i` counts exactly once, however long the pin stays low. With source 0, each cycle with `tick_i` high counts once.
- R12: While `borrow_i` is 1:
  - the effective run bit is `borrow_run_i`;
  - the flag follows `borrow_flag_i`;
  - `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_hi_i | input | 1 | Load high byte from wr_data_i |
| wr_lo_i | input | 1 | Load low byte from wr_data_i |
| wr_cfg_i | input | 1 | Load configuration from wr_data_i[4:0] |
| wr_flag_i | input | 1 | Load flag from wr_data_i[0] |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | Internal count strobe |
| evt_i | input | 1 | External event pin, counted on falling edges |
| gate_pin_ni | input | 1 | External active-low interrupt pin, high enables gated counting |
| borrow_i | input | 1 | Run bit and flag are controlled externally |
| borrow_run_i | input | 1 | External run bit used while borrowed |
| borrow_flag_i | input | 1 | External flag value used while borrowed |
| int_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| ie_local_i | input | 1 | Timer interrupt enable |
| ie_global_i | input | 1 | Global interrupt enable |
| hi_o | output | 8 | High byte |
| lo_o | output | 8 | Low byte |
| flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Each mode is driven from preloads near its rollover point and also from preloads far from it.

In mode 0, preloads with nonzero bits [7:5] show whether those bits are left alone while the 5-bit prescaler carries into the high byte. In mode 1, a carry from 0x00FE to 0x0101 is separated from a full wrap from 0xFFFE to 0x0001. In mode 2, the reload from the high byte is separated from a plain increment. In mode 3, a long tick burst shows that the count is held.

Directed cases cover the following:
- the gate pin in both states;
- held and released event levels;
- writes colliding with steps, and flag writes colliding with acknowledges;
- every combination of the interrupt enables;
- borrowed run and flag control.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      TM_PRESC  = 2'd0,
      TM_CASC   = 2'd1,
      TM_RELOAD = 2'd2,
      TM_FREEZE = 2'd3
   } tmr_mode_e;

   // Packed so that it maps directly onto write data bits [4:0].
   typedef struct packed {
      logic      run;
      logic      gate;
      logic      src;
      tmr_mode_e mode;
   } tmr_cfg_t;

   localparam int unsigned CFG_W = $bits(tmr_cfg_t);

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0,
   parameter bit          FALL_EDGE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic level_o,
   output logic edge_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= {STAGES{RESET_VAL}};
         prev_q <= RESET_VAL;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign level_o = sync_q[STAGES-1];

   if (FALL_EDGE) begin : g_fall
      assign edge_o = prev_q & ~level_o;
   end else begin : g_rise
      assign edge_o = ~prev_q & level_o;
   end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
   import tmr_pkg::*;
#(
   parameter int unsigned W        = 8,
   parameter int unsigned PRE_BITS = 5
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  tmr_mode_e    mode_i,
   input  logic         inc_i,
   input  logic         wr_hi_i,
   input  logic         wr_lo_i,
   input  logic [W-1:0] wr_data_i,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o,
   output logic         ovf_o
);

   localparam int unsigned CW = 2 * W + 1;

   if (PRE_BITS == 0 || PRE_BITS >= W) begin : g_bad_pre
      $error("tmr_count: PRE_BITS must lie in 1..W-1");
   end

   logic [W-1:0]        hi_q, lo_q, hi_n, lo_n;
   logic [PRE_BITS-1:0] pre;
   logic [CW-1:0]       casc_sum;
   logic                step;

   assign step     = inc_i & ~(wr_hi_i | wr_lo_i);
   assign pre      = lo_q[PRE_BITS-1:0];
   assign casc_sum = {1'b0, hi_q, lo_q} + CW'(1);

   always_comb begin
      hi_n  = hi_q;
      lo_n  = lo_q;
      ovf_o = 1'b0;
      if (step) begin
         unique case (mode_i)
            TM_PRESC: begin
               lo_n[PRE_BITS-1:0] = pre + PRE_BITS'(1);
               if (&pre) begin
                  hi_n  = hi_q + W'(1);
                  ovf_o = &hi_q;
               end
            end
            TM_CASC: begin
               {ovf_o, hi_n, lo_n} = casc_sum;
            end
            TM_RELOAD: begin
               if (&lo_q) begin
                  lo_n  = hi_q;
                  ovf_o = 1'b1;
               end else begin
                  lo_n = lo_q + W'(1);
               end
            end
            default: ;
         endcase
      end
      if (wr_hi_i) hi_n = wr_data_i;
      if (wr_lo_i) lo_n = wr_data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end

   assign hi_o = hi_q;
   assign lo_o = lo_q;

   assert_freeze_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == TM_FREEZE && !wr_hi_i && !wr_lo_i) |=> ($stable(hi_q) && $stable(lo_q)));

   assert_presc_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == TM_PRESC && !wr_lo_i) |=> $stable(lo_q[W-1:PRE_BITS]));

   assert_reload_keeps_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == TM_RELOAD && !wr_hi_i) |=> $stable(hi_q));

   assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !wr_hi_i && !wr_lo_i) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ovf_i,
   input  logic wr_i,
   input  logic wr_val_i,
   input  logic ack_i,
   input  logic borrow_i,
   input  logic borrow_flag_i,
   input  logic ie_local_i,
   input  logic ie_global_i,
   output logic flag_o,
   output logic irq_o
);

   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (borrow_i) flag_q <= borrow_flag_i;
      else if (wr_i)     flag_q <= wr_val_i;
      else if (ovf_i)    flag_q <= 1'b1;
      else if (ack_i)    flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & ie_local_i & ie_global_i & ~borrow_i;

   assert_ovf_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!borrow_i && !wr_i && ovf_i) |=> flag_q);

   assert_ack_clears_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!borrow_i && !wr_i && !ovf_i && ack_i) |=> !flag_q);

   assert_flag_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!borrow_i && wr_i) |=> (flag_q == $past(wr_val_i)));

   assert_borrow_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      borrow_i |=> (flag_q == $past(borrow_flag_i)));

endmodule

// File: rtl/gated_timer.sv
module gated_timer
   import tmr_pkg::*;
#(
   parameter int unsigned W           = 8,
   parameter int unsigned PRE_BITS    = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_hi_i,
   input  logic         wr_lo_i,
   input  logic         wr_cfg_i,
   input  logic         wr_flag_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         tick_i,
   input  logic         evt_i,
   input  logic         gate_pin_ni,
   input  logic         borrow_i,
   input  logic         borrow_run_i,
   input  logic         borrow_flag_i,
   input  logic         int_ack_i,
   input  logic         ie_local_i,
   input  logic         ie_global_i,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o,
   output logic         flag_o,
   output logic         irq_o
);

   if (W <= CFG_W) begin : g_bad_w
      $error("gated_timer: W must exceed the configuration width");
   end

   tmr_cfg_t cfg_q;
   logic     gate_lvl, evt_fall, inc, ovf, run_eff;
   logic     unused_gate_edge, unused_evt_lvl, unused_cfg_hi;

   assign unused_cfg_hi = ^wr_data_i[W-1:CFG_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q <= '0;
      else if (wr_cfg_i) cfg_q <= tmr_cfg_t'(wr_data_i[CFG_W-1:0]);
   end

   tmr_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALL_EDGE(1'b1)) u_gate_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (gate_pin_ni),
      .level_o(gate_lvl),
      .edge_o (unused_gate_edge)
   );

   tmr_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0), .FALL_EDGE(1'b1)) u_evt_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (evt_i),
      .level_o(unused_evt_lvl),
      .edge_o (evt_fall)
   );

   assign run_eff = borrow_i ? borrow_run_i : cfg_q.run;
   assign inc     = run_eff & (~cfg_q.gate | gate_lvl) & (cfg_q.src ? evt_fall : tick_i);

   tmr_count #(.W(W), .PRE_BITS(PRE_BITS)) u_count (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (cfg_q.mode),
      .inc_i    (inc),
      .wr_hi_i  (wr_hi_i),
      .wr_lo_i  (wr_lo_i),
      .wr_data_i(wr_data_i),
      .hi_o     (hi_o),
      .lo_o     (lo_o),
      .ovf_o    (ovf)
   );

   tmr_flag u_flag (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ovf_i        (ovf),
      .wr_i         (wr_flag_i),
      .wr_val_i     (wr_data_i[0]),
      .ack_i        (int_ack_i),
      .borrow_i     (borrow_i),
      .borrow_flag_i(borrow_flag_i),
      .ie_local_i   (ie_local_i),
      .ie_global_i  (ie_global_i),
      .flag_o       (flag_o),
      .irq_o        (irq_o)
   );

   assert_stopped_no_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_eff && !wr_hi_i && !wr_lo_i) |=> ($stable(hi_o) && $stable(lo_o)));

endmodule

// File: tb/gated_timer_tb.sv
module gated_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_hi = 0, wr_lo = 0, wr_cfg = 0, wr_flag = 0;
   logic [7:0] wr_data = '0;
   logic       tick = 0, evt = 1, gpin = 0;
   logic       borrow = 0, b_run = 0, b_flag = 0, ack = 0, ie_l = 0, ie_g = 0;
   logic [7:0] hi, lo;
   logic       flag, irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2 clk = ~clk;

   gated_timer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wr_cfg_i(wr_cfg),
      .wr_flag_i(wr_flag), .wr_data_i(wr_data), .tick_i(tick), .evt_i(evt),
      .gate_pin_ni(gpin), .borrow_i(borrow), .borrow_run_i(b_run),
      .borrow_flag_i(b_flag), .int_ack_i(ack), .ie_local_i(ie_l), .ie_global_i(ie_g),
      .hi_o(hi), .lo_o(lo), .flag_o(flag), .irq_o(irq)
   );

   // {mode, hi preload, lo preload, steps, expected hi, expected lo, expected flag}
   localparam int NV = 8;
   localparam logic [42:0] VEC [NV] = '{
      {2'd1, 8'h00, 8'hFE, 8'd3,  8'h01, 8'h01, 1'b0},
      {2'd1, 8'hFF, 8'hFE, 8'd3,  8'h00, 8'h01, 1'b1},
      {2'd0, 8'h00, 8'hE0, 8'd33, 8'h01, 8'hE1, 1'b0},
      {2'd0, 8'hFF, 8'hBF, 8'd2,  8'h00, 8'hA1, 1'b1},
      {2'd0, 8'h07, 8'h1E, 8'd3,  8'h08, 8'h01, 1'b0},
      {2'd2, 8'h80, 8'hFE, 8'd3,  8'h80, 8'h81, 1'b1},
      {2'd2, 8'h10, 8'h00, 8'd5,  8'h10, 8'h05, 1'b0},
      {2'd3, 8'h12, 8'h34, 8'd10, 8'h12, 8'h34, 1'b0}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int sel, input logic [7:0] d);
      @(negedge clk);
      wr_data = d;
      case (sel)
         0: wr_hi = 1;
         1: wr_lo = 1;
         2: wr_cfg = 1;
         default: wr_flag = 1;
      endcase
      @(negedge clk);
      wr_hi = 0; wr_lo = 0; wr_cfg = 0; wr_flag = 0;
   endtask

   // cfg byte: [4] run, [3] gate, [2] src, [1:0] mode
   function automatic logic [7:0] cfg(input bit run, input bit gate, input bit src,
                                      input logic [1:0] mode);
      return {3'b000, run, gate, src, mode};
   endfunction

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic preload(input logic [1:0] mode, input logic [7:0] h, input logic [7:0] l);
      wr(2, cfg(0, 0, 0, mode));
      wr(0, h);
      wr(1, l);
      wr(3, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R1: reset state
      check("R1 hi", {8'h0, hi}, 16'h0);
      check("R1 lo", {8'h0, lo}, 16'h0);
      check("R1 flag/irq", {14'h0, flag, irq}, 16'h0);
      rst_n = 1;
      idle(2);
      ie_l = 1; ie_g = 1;
      check("R1 irq after reset", {15'h0, irq}, 16'h0);
      ticks(3);
      check("R1 run off after reset", {hi, lo}, 16'h0000);
      ie_l = 0; ie_g = 0;

      // Mode table: R3 (mode 0), R4 (mode 1), R5 (mode 2), R6 (mode 3), R7 flag
      for (int v = 0; v < NV; v++) begin
         logic [1:0] m;
         string      tag;
         m = VEC[v][42:41];
         tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
         preload(m, VEC[v][40:33], VEC[v][32:25]);
         wr(2, cfg(1, 0, 0, m));
         ticks(int'(VEC[v][24:17]));
         check(tag, {hi, lo}, {VEC[v][16:9], VEC[v][8:1]});
         check("R7 flag", {15'h0, flag}, {15'h0, VEC[v][0]});
      end

      // R2: gate bit with pin low blocks counting, pin high allows it
      preload(2'd1, 8'h00, 8'h00);
      gpin = 0;
      wr(2, cfg(1, 1, 0, 2'd1));
      idle(4);
      ticks(3);
      check("R2 gated pin low", {hi, lo}, 16'h0000);
      gpin = 1;
      idle(4);
      ticks(3);
      check("R2 gated pin high", {hi, lo}, 16'h0003);
      wr(2, cfg(0, 0, 0, 2'd1));
      ticks(2);
      check("R2 run off", {hi, lo}, 16'h0003);

      // R11: external event source, one count per falling edge
      wr(2, cfg(1, 0, 1, 2'd1));
      ticks(4);
      check("R11 tick ignored in event mode", {hi, lo}, 16'h0003);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); evt = 0;
         idle(8);
         @(negedge clk); evt = 1;
         idle(6);
      end
      check("R11 event edges", {hi, lo}, 16'h0006);

      // R9: write collides with a step; step and its rollover are dropped
      preload(2'd1, 8'hFF, 8'hFF);
      wr(2, cfg(1, 0, 0, 2'd1));
      @(negedge clk); tick = 1; wr_hi = 1; wr_data = 8'h55;
      @(negedge clk); tick = 0; wr_hi = 0;
      check("R9 write beats step", {hi, lo}, 16'h55FF);
      check("R9 no rollover flag", {15'h0, flag}, 16'h0);
      @(negedge clk); tick = 1; wr_lo = 1; wr_data = 8'h20;
      @(negedge clk); tick = 0; wr_lo = 0;
      check("R9 lo write beats step", {hi, lo}, 16'h5520);

      // R7/R8: flag and interrupt gating
      preload(2'd2, 8'h00, 8'hFF);
      wr(2, cfg(1, 0, 0, 2'd2));
      ticks(1);
      check("R7 reload rollover", {hi, lo, 7'h0, flag}, {16'h0000, 8'h01});
      ie_l = 1; ie_g = 1; idle(1);
      check("R8 both enables", {15'h0, irq}, 16'h1);
      ie_g = 0; idle(1);
      check("R8 global off", {15'h0, irq}, 16'h0);
      ie_l = 0; ie_g = 1; idle(1);
      check("R8 local off", {15'h0, irq}, 16'h0);
      ie_l = 1;
      idle(5);
      check("R7 flag persists", {15'h0, flag}, 16'h1);
      @(negedge clk); ack = 1;
      @(negedge clk); ack = 0;
      check("R7 ack clears", {14'h0, flag, irq}, 16'h0);

      // R7: rollover and acknowledge in the same cycle keep the flag set
      wr(1, 8'hFF);
      @(negedge clk); tick = 1; ack = 1;
      @(negedge clk); tick = 0; ack = 0;
      check("R7 rollover beats ack", {15'h0, flag}, 16'h1);

      // R10: flag write and acknowledge in the same cycle
      wr(3, 8'h00);
      check("R10 flag write 0", {15'h0, flag}, 16'h0);
      @(negedge clk); wr_flag = 1; wr_data = 8'h01; ack = 1;
      @(negedge clk); wr_flag = 0; ack = 0;
      check("R10 write beats ack", {15'h0, flag}, 16'h1);
      wr(3, 8'h00);

      // R12: borrowed run and flag control
      preload(2'd1, 8'h00, 8'h00);
      borrow = 1; b_run = 1; b_flag = 1;
      ticks(2);
      check("R12 borrowed run counts", {hi, lo}, 16'h0002);
      check("R12 flag follows input", {15'h0, flag}, 16'h1);
      check("R12 irq muted", {15'h0, irq}, 16'h0);
      b_run = 0; b_flag = 0;
      ticks(2);
      check("R12 borrowed run off", {hi, lo}, 16'h0002);
      check("R12 flag follows low", {15'h0, flag}, 16'h0);

      // R6: freeze ignores the borrowed run bit
      b_run = 1;
      wr(2, cfg(1, 0, 0, 2'd3));
      ticks(4);
      check("R6 freeze with borrow", {hi, lo}, 16'h0002);
      borrow = 0;

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule